// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. It is clocked by the system clock and advances its bit timing only on an enable pulse that arrives at sixteen times the bit rate. A divider or an external clock pin may produce that pulse. The receiver realigns its timing on the falling edge of every start bit and samples each later bit once, near its centre.

A mode word sets the character format at run time. Bit 6 selects 7 or 8 data bits. Bit 5 adds a parity bit, bit 4 picks odd or even parity, and bit 3 picks one or two stop bits. The format is captured when a start bit is seen, so it stays fixed for that whole character.

Each finished character goes into a sixteen-entry buffer together with its own parity and framing error marks. The host sees the oldest entry at the read ports without waiting a cycle, and removes it by pulsing a pop input. The block also reports:
- the fill count;
- a full flag and a data-ready flag;
- a sticky overrun flag and a sticky line-break flag, both cleared by one clear input;
- a request-to-send output that falls when the buffer is nearly full.

Top module: `serial_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it, the fill count is 0, rts_o is 1, and data_ready_o, fifo_full_o, overrun_o and break_o are all 0.
- R2: Data bits arrive LSB first. With mode bit 6 = 0, eight bits are received. With mode bit 6 = 1, seven bits are received and rdata_o[7] reads 0.
- R3: With mode bit 5 = 1, one parity bit follows the data. Mode bit 4 = 0 selects even parity, where the data bits and the parity bit together hold an even number of ones. Mode bit 4 = 1 selects odd parity. On a mismatch, that character's entry carries rd_perr_o = 1. With mode bit 5 = 0, rd_perr_o is always 0.
- R4: Mode bit 3 = 0 selects one stop bit and mode bit 3 = 1 selects two. If any stop bit is sampled low in a character that is not a break, that character's entry carries rd_ferr_o = 1.
- R5: A low pulse on the line that has ended before the middle of the start bit (eight enable pulses) is ignored, and no entry is stored.
- R6: The buffer holds up to DEPTH (16) entries in arrival order. The oldest entry is shown at the read ports, pop_i removes it, and fill_o gives the number of entries stored.
- R7: fifo_full_o is 1 exactly when 16 entries are stored. data_ready_o is 1 exactly when at least one entry is stored.
- R8: If a character completes while 16 entries are stored and no pop happens in that cycle, the character is dropped and overrun_o is set. overrun_o stays set until clr_i is pulsed.
- R9: If the line stays low through the start bit, the data bits, the parity bit and every stop bit, break_o is set and no entry is stored. break_o stays set until clr_i is pulsed. After a break, or after a low last stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R10: rts_o is 0 while fill_o is 14 (RTS_LEVEL) or more, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| mode_i | input | 8 | Format word: bit 6 = seven data bits, bit 5 = parity on, bit 4 = odd parity, bit 3 = two stop bits |
| pop_i | input | 1 | Removes the oldest buffer entry |
| clr_i | input | 1 | Clears the overrun and break flags |
| rdata_o | output | 8 | Data of the oldest entry |
| rd_perr_o | output | 1 | Parity error mark of the oldest entry |
| rd_ferr_o | output | 1 | Framing error mark of the oldest entry |
| fill_o | output | 5 | Number of stored entries |
| data_ready_o | output | 1 | Buffer is not empty |
| fifo_full_o | output | 1 | Buffer holds 16 entries |
| overrun_o | output | 1 | Sticky flag: a character was lost |
| break_o | output | 1 | Sticky flag: a line break was seen |
| rts_o | output | 1 | Request to send; low when the buffer is nearly full |

## Verification
The assertions check the buffer bookkeeping on every cycle:
- the fill count never goes above the depth and never moves by more than one per cycle;
- the full, ready and request-to-send outputs agree with the count;
- the overrun and break flags stay set until a clear;
- overrun only rises when the buffer was full.

Only the bench scenarios can show the character-level behaviour: the bit order, 7-bit masking, parity sense, stop-bit checks, glitch rejection, break detection and recovery. To do this the bench drives whole serial frames under many random mode words and compares each entry it pops with a model of the frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int DATA_W = 8;
  localparam int MODE_W = 8;

  // Mode word bit positions
  localparam int MODE_SEVEN = 6;
  localparam int MODE_PEN   = 5;
  localparam int MODE_PODD  = 4;
  localparam int MODE_STOP2 = 3;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  localparam int CHAR_W = $bits(rx_char_t);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              push_o,
  output rx_char_t          char_o,
  output logic              brk_o
);

  localparam int SUB_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  rx_state_t         state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [MODE_W-1:0] mode_q;
  logic              par_q;
  logic              ferr_q;
  logic              zero_q;
  logic              extra_stop_q;

  logic [IDX_W-1:0]  last_idx;
  logic              exp_par;
  logic              perr_c;
  logic              at_mid_bit;

  // Index of the last data bit for the current format (R2)
  assign last_idx   = mode_q[MODE_SEVEN] ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  // Parity sense is picked by the mode word (R3)
  assign exp_par    = (^data_q) ^ mode_q[MODE_PODD];
  assign perr_c     = mode_q[MODE_PEN] && (par_q != exp_par);
  assign at_mid_bit = (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RX_IDLE;
      sub_q        <= '0;
      idx_q        <= '0;
      data_q       <= '0;
      mode_q       <= '0;
      par_q        <= 1'b0;
      ferr_q       <= 1'b0;
      zero_q       <= 1'b1;
      extra_stop_q <= 1'b0;
      push_o       <= 1'b0;
      brk_o        <= 1'b0;
      char_o       <= '0;
    end else begin
      push_o <= 1'b0;
      brk_o  <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: begin
            if (!rxd_i) begin
              state_q <= RX_START;
              sub_q   <= '0;
              mode_q  <= mode_i;
            end
          end
          RX_START: begin
            if (sub_q == SUB_MID) begin
              sub_q <= '0;
              if (rxd_i) begin
                state_q <= RX_IDLE;        // glitch rejected (R5)
              end else begin
                state_q <= RX_DATA;
                idx_q   <= '0;
                data_q  <= '0;
                zero_q  <= 1'b1;
                ferr_q  <= 1'b0;
                par_q   <= 1'b0;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_mid_bit) begin
              sub_q          <= '0;
              data_q[idx_q]  <= rxd_i;     // LSB first (R2)
              if (rxd_i) zero_q <= 1'b0;
              if (idx_q == last_idx) begin
                state_q      <= mode_q[MODE_PEN] ? RX_PAR : RX_STOP;
                extra_stop_q <= mode_q[MODE_STOP2];
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_mid_bit) begin
              sub_q   <= '0;
              par_q   <= rxd_i;
              if (rxd_i) zero_q <= 1'b0;
              state_q <= RX_STOP;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_mid_bit) begin
              sub_q <= '0;
              if (!rxd_i) ferr_q <= 1'b1;
              if (rxd_i) zero_q <= 1'b0;
              if (extra_stop_q) begin
                extra_stop_q <= 1'b0;      // first of two stop bits (R4)
              end else if (zero_q && !rxd_i) begin
                brk_o   <= 1'b1;           // whole frame low (R9)
                state_q <= RX_HOLD;
              end else begin
                push_o  <= 1'b1;
                char_o  <= '{ferr: ferr_q | !rxd_i, perr: perr_c, data: data_q};
                state_q <= rxd_i ? RX_IDLE : RX_HOLD;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_HOLD: begin
            if (rxd_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          is_full;
  logic          pop_ok;
  logic          push_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full = (count_q == CW'(DEPTH));
  assign pop_ok  = pop_i && (count_q != '0);
  // A pop in the same cycle frees the slot for the push (R8)
  assign push_ok = push_i && (!is_full || pop_ok);
  assign ovf_o   = push_i && !push_ok;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // Show-ahead read of the oldest entry (R6)
  assign rdata_o = mem[rd_ptr_q];
  assign count_o = count_q;

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RTS_LEVEL   = 14,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pop_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              data_ready_o,
  output logic              fifo_full_o,
  output logic              overrun_o,
  output logic              break_o,
  output logic              rts_o
);

  logic     rxd_s;
  logic     push;
  logic     brk_pulse;
  logic     ovf;
  rx_char_t new_char;
  rx_char_t head_char;
  logic [CHAR_W-1:0] head_raw;
  logic [CNT_W-1:0]  count;
  logic     overrun_q;
  logic     break_q;

  serial_rx_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (rxd_s)
  );

  serial_rx_framer #(
    .OSR (OSR)
  ) u_framer (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick16_i),
    .rxd_i  (rxd_s),
    .mode_i (mode_i),
    .push_o (push),
    .char_o (new_char),
    .brk_o  (brk_pulse)
  );

  serial_rx_fifo #(
    .DEPTH (DEPTH),
    .W     (CHAR_W)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .wdata_i (new_char),
    .pop_i   (pop_i),
    .rdata_o (head_raw),
    .count_o (count),
    .ovf_o   (ovf)
  );

  // Sticky flags: a new event wins over a clear in the same cycle (R8, R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      overrun_q <= 1'b0;
      break_q   <= 1'b0;
    end else begin
      overrun_q <= ovf       | (overrun_q & ~clr_i);
      break_q   <= brk_pulse | (break_q   & ~clr_i);
    end
  end

  assign head_char    = rx_char_t'(head_raw);
  assign rdata_o      = head_char.data;
  assign rd_perr_o    = head_char.perr;
  assign rd_ferr_o    = head_char.ferr;
  assign fill_o       = count;
  assign data_ready_o = (count != '0);
  assign fifo_full_o  = (count == CNT_W'(DEPTH));
  assign rts_o        = (count < CNT_W'(RTS_LEVEL));   // R10
  assign overrun_o    = overrun_q;
  assign break_o      = break_q;

endmodule

// File: rtl/serial_rx_sva.sv
module serial_rx_sva #(
  parameter int DEPTH     = 16,
  parameter int RTS_LEVEL = 14,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pop_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] fill_o,
  input logic             data_ready_o,
  input logic             fifo_full_o,
  input logic             overrun_o,
  input logic             break_o,
  input logic             rts_o
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fill_o == '0) && rts_o && !overrun_o && !break_o && !data_ready_o);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fill_o <= CNT_W'(DEPTH));

  p_fill_step_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + 1'b1) ||
             (fill_o == $past(fill_o) - 1'b1));

  p_pop_drains_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_i && fill_o != '0) |=> fill_o <= $past(fill_o));

  p_full_flag_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_full_o |-> (fill_o == CNT_W'(DEPTH)) && data_ready_o);

  p_ready_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !data_ready_o |-> (fill_o == '0) && !fifo_full_o);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !clr_i) |=> overrun_o);

  p_ovr_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(fill_o) == CNT_W'(DEPTH));

  p_brk_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (break_o && !clr_i) |=> break_o);

  p_rts_high_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_o >= CNT_W'(RTS_LEVEL)) |-> !rts_o);

  p_rts_low_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_o < CNT_W'(RTS_LEVEL)) |-> rts_o);

endmodule

bind serial_rx serial_rx_sva #(
  .DEPTH     (DEPTH),
  .RTS_LEVEL (RTS_LEVEL)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .pop_i        (pop_i),
  .clr_i        (clr_i),
  .fill_o       (fill_o),
  .data_ready_o (data_ready_o),
  .fifo_full_o  (fifo_full_o),
  .overrun_o    (overrun_o),
  .break_o      (break_o),
  .rts_o        (rts_o)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int BIT        = 16 * DIV;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] mode = 8'h00;
  logic       pop = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] rdata;
  logic       rd_perr, rd_ferr;
  logic [4:0] fill;
  logic       data_ready, fifo_full, overrun, brk, rts;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int tdiv   = 0;

  logic [9:0] mq [0:63];
  int mh = 0;
  int mt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == DIV - 1);
  end

  serial_rx dut (
    .clk (clk), .rst (rst), .tick16_i (tick16), .rxd_i (rxd), .mode_i (mode),
    .pop_i (pop), .clr_i (clr), .rdata_o (rdata), .rd_perr_o (rd_perr),
    .rd_ferr_o (rd_ferr), .fill_o (fill), .data_ready_o (data_ready),
    .fifo_full_o (fifo_full), .overrun_o (overrun), .break_o (brk), .rts_o (rts)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic seven, input logic odd);
    logic [7:0] m;
    m = seven ? {1'b0, d[6:0]} : d;
    return (^m) ^ odd;
  endfunction

  task automatic line(input logic v, input int nbits);
    rxd = v;
    repeat (BIT * nbits) @(negedge clk);
  endtask

  // Drives one frame; stores the expected entry in the model when keep=1
  task automatic send(input logic [7:0] d, input logic [7:0] m, input bit bad_par,
                      input bit bad_stop, input bit keep);
    logic [7:0] ed;
    mode = m;
    line(1'b0, 1);
    for (int i = 0; i < (m[6] ? 7 : 8); i++) line(d[i], 1);
    if (m[5]) line(par_of(d, m[6], m[4]) ^ bad_par, 1);
    line(!bad_stop, 1);
    if (m[3]) line(1'b1, 1);
    line(1'b1, 2);
    ed = m[6] ? {1'b0, d[6:0]} : d;
    if (keep) begin
      mq[mt % 64] = {bad_stop, bad_par & m[5], ed};
      mt++;
    end
  endtask

  task automatic pop_expect(input string req);
    logic [9:0] e;
    e = mq[mh % 64];
    mh++;
    check(data_ready == 1'b1, req, "data_ready before pop", data_ready, 1);
    check({rd_ferr, rd_perr, rdata} == e, req, "entry {ferr,perr,data}",
          {rd_ferr, rd_perr, rdata}, e);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, d;
    bit bp, bs;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(fill == 0 && rts && !data_ready && !fifo_full && !overrun && !brk,
          "R1", "reset outputs", {fill, rts, data_ready, fifo_full, overrun, brk}, 6'b000001_0 >> 1);
    rst = 1'b0;
    @(negedge clk);
    check(fill == 0 && rts && !overrun && !brk, "R1", "after reset",
          {fill, rts, overrun, brk}, 8'b0000_0100);

    // Directed: 7-bit mode masks bit 7 (R2)
    send(8'hFF, 8'h40, 0, 0, 1);
    pop_expect("R2 seven-bit");
    // Directed: 8-bit LSB first pattern (R2)
    send(8'h81, 8'h00, 0, 0, 1);
    pop_expect("R2 lsb-first");
    // Directed: even and odd parity good and bad (R3)
    send(8'h07, 8'h20, 0, 0, 1);
    pop_expect("R3 even good");
    send(8'h07, 8'h30, 1, 0, 1);
    pop_expect("R3 odd bad");
    // Directed: framing error with two stop bits, first one low (R4)
    send(8'h5A, 8'h28, 0, 1, 1);
    pop_expect("R4 two-stop ferr");
    send(8'h33, 8'h00, 0, 1, 1);
    pop_expect("R4 one-stop ferr");

    // Random formats (R2 R3 R4 R6)
    for (int k = 0; k < 40; k++) begin
      m  = {1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'b000};
      d  = 8'($urandom);
      bp = m[5] && ($urandom % 4 == 0);
      bs = ($urandom % 6 == 0);
      if (bs) d = d | 8'h01;
      send(d, m, bp, bs, 1);
      check(fill == 1, "R6", "fill after one frame", fill, 1);
      pop_expect("R2 R3 R4 random");
      check(fill == 0 && !data_ready, "R7", "empty after pop", fill, 0);
    end

    // Glitch shorter than half a bit (R5)
    rxd = 1'b0;
    repeat (5 * DIV) @(negedge clk);
    line(1'b1, 3);
    check(fill == 0 && !data_ready, "R5", "glitch stored nothing", fill, 0);

    // Fill to full, thresholds and overrun (R6 R7 R8 R10)
    for (int k = 0; k < 17; k++) begin
      send(8'(k + 8'h10), 8'h00, 0, 0, k < DEPTH);
      if (k == 12) check(rts == 1 && fill == 13, "R10", "rts at 13", rts, 1);
      if (k == 13) check(rts == 0 && fill == 14, "R10", "rts at 14", rts, 0);
      if (k == 15) begin
        check(fill == 16, "R6", "fill at 16", fill, 16);
        check(fifo_full == 1, "R7", "full at 16", fifo_full, 1);
        check(overrun == 0, "R8", "no overrun yet", overrun, 0);
      end
    end
    check(overrun == 1, "R8", "overrun after 17th", overrun, 1);
    check(fill == 16, "R8", "17th dropped", fill, 16);
    pop_expect("R6 order");
    check(fill == 15 && rts == 0 && !fifo_full, "R10", "rts at 15", rts, 0);
    pop_expect("R6 order");
    pop_expect("R6 order");
    check(fill == 13 && rts == 1, "R10", "rts back at 13", rts, 1);
    for (int k = 0; k < 13; k++) pop_expect("R6 order");
    check(fill == 0, "R6", "drained", fill, 0);
    check(overrun == 1, "R8", "overrun sticky", overrun, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(overrun == 0, "R8", "overrun cleared", overrun, 0);

    // Break (R9)
    mode = 8'h28;
    line(1'b0, 14);
    check(brk == 1, "R9", "break set while low", brk, 1);
    check(fill == 0, "R9", "no entry for break", fill, 0);
    line(1'b1, 2);
    check(brk == 1, "R9", "break sticky", brk, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(brk == 0, "R9", "break cleared", brk, 0);
    send(8'hC3, 8'h00, 0, 0, 1);
    pop_expect("R9 recovery");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule